// File: doc/BRIEF.md
# Manchester Line Encoder with Selectable Idle

This block turns NRZ transmit data from a MAC-style controller into a Manchester-coded two-wire line state for an external differential driver. It runs from a reference clock at twice the bit rate. It divides that clock by two and returns the result to the controller as the transmit clock. The controller presents an enable and one data bit per transmit-clock period. The block samples both on the rising transmit-clock edge and produces one half-cell value per reference cycle.

When the enable is seen low, the frame ends. The line is then driven so that the last transition is always low-to-high. After that, the line holds at the positive level for a fixed number of reference cycles. Then it rests in one of two idle states, chosen by a select input: zero differential, for transformer-coupled links, or a static positive level.

Top module: `manTxEncoder`

## Requirements
- R1: `txClk` toggles on every reference-clock edge after reset, so its period is two reference cycles.
- R2: While `rstN` is low, `lineState` is 2'b00 and `txClk` is 0.
- R3: `txEn` and `txData` are sampled on the reference edge at which `txClk` rises. When that sample starts or continues a frame, `lineState` takes the bit's first half-cell value at that same edge.
- R4: Line codes are 2'b10 = positive, 2'b01 = negative, 2'b00 = zero. A 0 bit is positive, then negative; a 1 bit is negative, then positive. The second half-cell value appears on the edge at which `txClk` falls, so every cell has a mid-cell transition.
- R5: A frame ends on the first rising-`txClk` sample with `txEn` low. From that edge the line is positive. After a final 1, the line is already positive from mid-cell. After a final 0, the line rises at the cell boundary.
- R6: The positive level after a frame lasts `HOLD_CYCLES` (default 4, i.e. 200 ns at 20 MHz) reference cycles, counted from the edge that sampled `txEn` low.
- R7: When no frame is in progress, the line is 2'b00 while `idleZero` is 1 and 2'b10 while it is 0. A change of `idleZero` shows on the line one reference edge later.
- R8: `lineState` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock, twice the bit rate |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Frame enable from the controller |
| txData | input | 1 | NRZ data bit from the controller |
| idleZero | input | 1 | 1: zero-differential idle; 0: positive idle |
| txClk | output | 1 | Divided transmit clock to the controller |
| lineState | output | 2 | Encoded line state: 10 positive, 01 negative, 00 zero |

## Verification
Two actions can fall on the same reference edge: the frame-end termination and the last bit's cell boundary. The edge that samples `txEn` low is also the edge that would begin a new cell. After a final 0, that edge must lift the line from negative to positive, not start another cell or go to idle. A second collision happens when the hold expires: the expiry shares an edge with a rising `txClk`, where idle and a new frame start compete. Frames ending in 0 and in 1 are sent under both idle selections. A queue of per-cycle expected line codes, built from the bit values, is compared against the line on every reference cycle, including across these shared edges.

// File: rtl/manTxPkg.sv
package manTxPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } txState_e;

  localparam logic [1:0] LINE_ZERO = 2'b00;
  localparam logic [1:0] LINE_POS  = 2'b10;
  localparam logic [1:0] LINE_NEG  = 2'b01;

  // strobes from control to datapath, at most one set per reference cycle
  typedef struct packed {
    logic takeBit;     // capture txData, drive first half-cell
    logic secondHalf;  // drive inverted half-cell
    logic forceHigh;   // frame termination / post-frame hold
    logic goIdle;      // drive the selected idle level
  } txStrobe_t;
endpackage

// File: rtl/manTxCtrl.sv
module manTxCtrl
  import manTxPkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic      txEn,
  output logic      txClk,
  output txStrobe_t stb
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic             phase;
  txState_e         state;
  logic [CNT_W-1:0] holdCnt;
  logic             sampleEdge;

  // the edge at which phase leaves 0 is the rising edge of txClk
  assign sampleEdge = ~phase;
  assign txClk      = phase;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      phase <= ~phase;
      case (state)
        ST_IDLE: if (sampleEdge && txEn) state <= ST_SEND;
        ST_SEND: if (sampleEdge && !txEn) begin
          state   <= ST_HOLD;
          holdCnt <= HOLD_LOAD;
        end
        ST_HOLD: begin
          if (holdCnt == '0) state <= ST_IDLE;
          else holdCnt <= holdCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.takeBit    = sampleEdge && txEn && (state == ST_IDLE || state == ST_SEND);
    stb.secondHalf = !sampleEdge && (state == ST_SEND);
    stb.forceHigh  = (state == ST_SEND && sampleEdge && !txEn) ||
                     (state == ST_HOLD && holdCnt != '0);
    stb.goIdle     = (state == ST_IDLE && !stb.takeBit) ||
                     (state == ST_HOLD && holdCnt == '0);
  end

  AST_CLK_TOGGLE: assert property (@(posedge refClk) disable iff (!rstN)
    1'b1 |=> txClk != $past(txClk)); // R1
  AST_HOLD_EXIT: assert property (@(posedge refClk) disable iff (!rstN)
    (state == ST_HOLD && holdCnt == '0) |=> state == ST_IDLE); // R6
  AST_ONE_STROBE: assert property (@(posedge refClk) disable iff (!rstN)
    $onehot0(stb)); // R3
endmodule

// File: rtl/manTxDp.sv
module manTxDp
  import manTxPkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       txData,
  input  logic       idleZero,
  input  txStrobe_t  stb,
  output logic [1:0] lineState
);
  logic bitReg;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      bitReg    <= 1'b0;
      lineState <= LINE_ZERO;
    end else if (stb.takeBit) begin
      bitReg    <= txData;
      lineState <= txData ? LINE_NEG : LINE_POS;
    end else if (stb.secondHalf) begin
      lineState <= bitReg ? LINE_POS : LINE_NEG;
    end else if (stb.forceHigh) begin
      lineState <= LINE_POS;
    end else if (stb.goIdle) begin
      lineState <= idleZero ? LINE_ZERO : LINE_POS;
    end
  end

  AST_NO_BOTH: assert property (@(posedge refClk) disable iff (!rstN)
    lineState != 2'b11); // R8
  AST_MID_FLIP: assert property (@(posedge refClk) disable iff (!rstN)
    stb.secondHalf |=> lineState == {$past(lineState[0]), $past(lineState[1])}); // R4
endmodule

// File: rtl/manTxEncoder.sv
module manTxEncoder
  import manTxPkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       txData,
  input  logic       idleZero,
  output logic       txClk,
  output logic [1:0] lineState
);
  txStrobe_t stb;

  manTxCtrl #(.HOLD_CYCLES(HOLD_CYCLES)) ctrl (
    .refClk (refClk),
    .rstN   (rstN),
    .txEn   (txEn),
    .txClk  (txClk),
    .stb    (stb)
  );

  manTxDp dp (
    .refClk    (refClk),
    .rstN      (rstN),
    .txData    (txData),
    .idleZero  (idleZero),
    .stb       (stb),
    .lineState (lineState)
  );

  AST_END_HIGH: assert property (@(posedge refClk) disable iff (!rstN)
    stb.forceHigh |=> lineState == LINE_POS); // R5
endmodule

// File: tb/manTxEncoder_test.sv
module manTxEncoder_test;
  import manTxPkg::*;

  localparam int HOLD = 4;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic txEn = 1'b0;
  logic txData = 1'b0;
  logic idleZero = 1'b1;
  logic txClk;
  logic [1:0] lineState;

  always #10 refClk = ~refClk;

  manTxEncoder #(.HOLD_CYCLES(HOLD)) uut (
    .refClk    (refClk),
    .rstN      (rstN),
    .txEn      (txEn),
    .txData    (txData),
    .idleZero  (idleZero),
    .txClk     (txClk),
    .lineState (lineState)
  );

  typedef struct {
    logic [1:0] v;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t monItem;
  int checks = 0;
  int errors = 0;
  logic prevClk = 1'b0;
  bit clkSeen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  function automatic logic [1:0] idleExp();
    return idleZero ? LINE_ZERO : LINE_POS;
  endfunction

  task automatic push(input logic [1:0] v, input string req);
    expItem_t it;
    it.v = v;
    it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: compares the line after each reference edge
  always begin
    @(posedge refClk);
    #5;
    if (rstN) begin
      if (expQ.size() > 0) begin
        monItem = expQ.pop_front();
        check(lineState === monItem.v, monItem.req, "line state", lineState, monItem.v);
      end
      check(lineState !== 2'b11, "R8", "illegal code", lineState, 2'b00);
      if (clkSeen)
        check(txClk !== prevClk, "R1", "txClk toggle", {1'b0, txClk}, {1'b0, ~prevClk});
      prevClk = txClk;
      clkSeen = 1'b1;
    end
  end

  task automatic idleCycles(input int n);
    repeat (n) begin
      @(negedge refClk);
      txEn = 1'b0;
      push(idleExp(), "R7");
    end
  endtask

  task automatic setSel(input logic v);
    @(negedge refClk);
    idleZero = v;
    txEn = 1'b0;
    push(idleExp(), "R7");
  endtask

  task automatic sendFrame(input logic [15:0] bits, input int n);
    @(negedge refClk);
    while (txClk) begin
      txEn = 1'b0;
      push(idleExp(), "R7");
      @(negedge refClk);
    end
    for (int i = n - 1; i >= 0; i--) begin
      txEn = 1'b1;
      txData = bits[i];
      push(bits[i] ? LINE_NEG : LINE_POS, "R3");
      @(negedge refClk);
      push(bits[i] ? LINE_POS : LINE_NEG, "R4");
      @(negedge refClk);
    end
    txEn = 1'b0;
    txData = 1'b0;
    push(LINE_POS, "R5");
    repeat (HOLD - 1) begin
      @(negedge refClk);
      push(LINE_POS, "R6");
    end
    @(negedge refClk);
    push(idleExp(), "R7");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge refClk);
    check(lineState === LINE_ZERO, "R2", "reset line", lineState, LINE_ZERO);
    check(txClk === 1'b0, "R2", "reset txClk", {1'b0, txClk}, 2'b00);
    rstN = 1'b1;
    push(idleExp(), "R7");
    idleCycles(3);
    // zero-differential idle, frame ends in 1
    sendFrame(16'b1011, 4);
    // frame ends in 0
    sendFrame(16'b0100, 4);
    idleCycles(2);
    // positive idle selection
    setSel(1'b0);
    idleCycles(3);
    sendFrame(16'b0110, 4);
    sendFrame(16'b1, 1);
    sendFrame(16'b0, 1);
    setSel(1'b1);
    idleCycles(4);
    sendFrame(16'b1100_1010, 8);
    idleCycles(2);
    repeat (2) @(posedge refClk);
    #6;
    check(expQ.size() == 0, "R3", "queue drained", 2'(expQ.size() > 0), 2'b00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule